// File: doc/BRIEF.md
# Rotating Bus Arbiter with Privileged Interleave

This block decides which of several masters owns a shared parallel bus. Every master has its own active-low request line and its own active-low grant line. The arbiter holds a grant for the whole of a transaction. It decides again only when the bus has no owner, or when the owner's transaction closes, which is signalled by a one-cycle end strobe.

Two policies are available, chosen by a mode input. In plain rotation every requesting master gets one transaction in turn. The search starts one place past the master served last. In fair rotation, one master fixed at build time is the privileged master, for example a boot processor. It is offered every other transaction slot. The remaining masters rotate among themselves in the slots between. A slot that its owner does not claim goes to the other side, so no decision is wasted.

Top module: `bus_rotor_arbiter`

## Requirements
- R1: Grant lines are active low (0 = granted), and at most one grant line is low at any time.
- R2: While reset is active, and at the first edge after it, every grant line is high. Reset leaves the rotation pointer at master 0 and the privileged slot flag set.
- R3: Once a master holds a grant, every grant line stays unchanged until a cycle in which the end strobe is high.
- R4: A decision is taken at every clock edge where the end strobe is high or no master holds a grant. A winner chosen at an edge drives its grant line low from that edge on.
- R5: When exactly one master requests at a decision, that master is granted, wherever the rotation pointer stands.
- R6: With the mode input at 0 (plain rotation), the winner is the first requesting master found by searching upward, with wrap-around, from the pointer. The pointer then moves to the winner's index plus one, modulo the number of masters.
- R7: With the mode input at 1 (fair rotation), if the privileged-slot flag is set and the privileged master (index PRIV_IDX, default 0) requests, that master wins and the flag clears. A privileged grant in this mode leaves the pointer unchanged.
- R8: In fair rotation, a slot not taken by the privileged master goes to the first requesting non-privileged master found upward from the pointer. The pointer then moves past that master and the flag is set.
- R9: In fair rotation, a privileged slot that the privileged master leaves unused goes to a requesting group master. A group slot with no group request goes to the privileged master if it requests.
- R10: When no master requests at a decision, all grant lines go high, and the pointer and the slot flag keep their values.
- R11: A grant line only goes low for a master whose request line was low at the deciding edge.
- R12: In plain rotation the slot flag is neither read nor changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | NUM_MASTERS | Request per master, active low |
| xfer_end | input | 1 | One-cycle strobe marking the end of the current transaction |
| fair_mode | input | 1 | 0 = plain rotation, 1 = fair rotation with the privileged master |
| gnt_n | output | NUM_MASTERS | Grant per master, active low |

## Verification
A lone requester is placed far from the pointer to show that it is granted at once rather than when the rotation reaches it. Holding every request low, first in plain and then in fair mode, gives grant orders that differ from each other: 3,0,1,2 in plain mode against 0,1,0,2,0,3,0,1 in fair mode. These orders separate a correct pointer update and a correct slot alternation from off-by-one and stuck-flag faults. Requests that vanish while a grant is held, releases with no requests pending, and group-only or privileged-only request sets cover the hold, release and slot-donation rules. Random request and strobe patterns, with the mode switched mid-run, are then compared cycle by cycle against a reference model in the bench.

// File: rtl/rotor_arb_pkg.sv
package rotor_arb_pkg;

  // Index arithmetic modulo the master count, shared by the pickers and the top.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned n);
    return (base + step) % n;
  endfunction

endpackage

// File: rtl/rotor_rr_pick.sv
module rotor_rr_pick
  import rotor_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] ptr,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Candidate k is the master k steps after the pointer.
  logic [IW-1:0] cand [N];
  logic [N-1:0]  hit;

  for (genvar k = 0; k < N; k++) begin : g_rot
    assign cand[k] = IW'(wrap_add(32'(ptr), k, N));
    assign hit[k]  = mask[cand[k]];
  end

  // The nearest hit wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found = 1'b1;
        idx   = cand[k];
      end
    end
  end

endmodule

// File: rtl/rotor_slot_sel.sv
module rotor_slot_sel #(
  parameter int N        = 4,
  parameter int IW       = (N > 1) ? $clog2(N) : 1,
  parameter int PRIV_IDX = 0
) (
  input  logic          fair_mode,
  input  logic          priv_req,
  input  logic          priv_turn,
  input  logic          all_found,
  input  logic [IW-1:0] all_idx,
  input  logic          grp_found,
  input  logic [IW-1:0] grp_idx,
  output logic          win_valid,
  output logic [IW-1:0] win_idx,
  output logic          ptr_adv,
  output logic          turn_next
);

  localparam logic [IW-1:0] PRIV = IW'(PRIV_IDX);

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    ptr_adv   = 1'b0;
    turn_next = priv_turn;
    if (!fair_mode) begin
      win_valid = all_found;
      win_idx   = all_idx;
      ptr_adv   = all_found;
    end else if (priv_turn && priv_req) begin
      win_valid = 1'b1;
      win_idx   = PRIV;
      turn_next = 1'b0;
    end else if (grp_found) begin
      win_valid = 1'b1;
      win_idx   = grp_idx;
      ptr_adv   = 1'b1;
      turn_next = 1'b1;
    end else if (priv_req) begin
      win_valid = 1'b1;
      win_idx   = PRIV;
      turn_next = 1'b0;
    end
  end

endmodule

// File: rtl/bus_rotor_arbiter.sv
module bus_rotor_arbiter
  import rotor_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int PRIV_IDX    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_n,
  input  logic                   xfer_end,
  input  logic                   fair_mode,
  output logic [NUM_MASTERS-1:0] gnt_n
);

  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam logic [NUM_MASTERS-1:0] PRIV_BIT = NUM_MASTERS'(1) << PRIV_IDX;

  logic [NUM_MASTERS-1:0] req;
  logic [NUM_MASTERS-1:0] grp_req;
  logic                   own_valid;
  logic [IW-1:0]          own_idx;
  logic [IW-1:0]          rr_ptr;
  logic                   priv_turn;
  logic                   arb_evt;

  logic          all_found, grp_found, win_valid, ptr_adv, turn_next;
  logic [IW-1:0] all_idx, grp_idx, win_idx;

  assign req     = ~req_n;
  assign grp_req = req & ~PRIV_BIT;
  assign arb_evt = xfer_end || !own_valid;

  rotor_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_pick_all (
    .mask (req),
    .ptr  (rr_ptr),
    .found(all_found),
    .idx  (all_idx)
  );

  rotor_rr_pick #(.N(NUM_MASTERS), .IW(IW)) u_pick_grp (
    .mask (grp_req),
    .ptr  (rr_ptr),
    .found(grp_found),
    .idx  (grp_idx)
  );

  rotor_slot_sel #(.N(NUM_MASTERS), .IW(IW), .PRIV_IDX(PRIV_IDX)) u_slot (
    .fair_mode(fair_mode),
    .priv_req (req[PRIV_IDX]),
    .priv_turn(priv_turn),
    .all_found(all_found),
    .all_idx  (all_idx),
    .grp_found(grp_found),
    .grp_idx  (grp_idx),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .ptr_adv  (ptr_adv),
    .turn_next(turn_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_valid <= 1'b0;
      own_idx   <= '0;
      rr_ptr    <= '0;
      priv_turn <= 1'b1;
    end else if (arb_evt) begin
      own_valid <= win_valid;
      if (win_valid) own_idx <= win_idx;
      if (ptr_adv)   rr_ptr  <= IW'(wrap_add(32'(win_idx), 1, NUM_MASTERS));
      priv_turn <= turn_next;
    end
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_gnt
    assign gnt_n[i] = !(own_valid && (own_idx == IW'(i)));
  end

endmodule

// File: rtl/rotor_arb_checks.sv
module rotor_arb_checks #(
  parameter int N = 4,
  parameter int P = 0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic [N-1:0] gnt_n,
  input logic         xfer_end,
  input logic         fair_mode,
  input logic         arb_evt,
  input logic         priv_turn
);

  logic [N-1:0] grp_req;
  always_comb begin
    grp_req    = ~req_n;
    grp_req[P] = 1'b0;
  end

  a_r1_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&gnt_n) && !xfer_end) |=> $stable(gnt_n));

  a_r4_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ((&gnt_n) && !(&req_n)) |=> !(&gnt_n));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_evt && (&req_n)) |=> (&gnt_n));

  a_r7_priv_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_evt && fair_mode && priv_turn && !req_n[P]) |=> !gnt_n[P]);

  a_r9_slot_donate: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_evt && fair_mode && req_n[P] && (|grp_req)) |=> (gnt_n[P] && !(&gnt_n)));

  a_r12_turn_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_evt && !fair_mode) |=> $stable(priv_turn));

  for (genvar i = 0; i < N; i++) begin : g_req
    a_r11_req_seen: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt_n[i]) |-> !$past(req_n[i]));
  end

endmodule

bind bus_rotor_arbiter rotor_arb_checks #(.N(NUM_MASTERS), .P(PRIV_IDX)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_n    (req_n),
  .gnt_n    (gnt_n),
  .xfer_end (xfer_end),
  .fair_mode(fair_mode),
  .arb_evt  (arb_evt),
  .priv_turn(priv_turn)
);

// File: tb/test_bus_rotor_arbiter.sv
module test_bus_rotor_arbiter;

  localparam int N = 4;
  localparam int P = 0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         xfer_end = 1'b0;
  logic         fair_mode = 1'b0;
  logic [N-1:0] gnt_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Reference state
  int m_own  = -1;
  int m_ptr  = 0;
  int m_turn = 1;

  always #10 clk = ~clk;

  bus_rotor_arbiter #(.NUM_MASTERS(N), .PRIV_IDX(P)) i_bus_rotor_arbiter (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .xfer_end(xfer_end),
    .fair_mode(fair_mode), .gnt_n(gnt_n)
  );

  function automatic int seek(input int start, input logic [N-1:0] m, input int skip);
    int pos = start;
    for (int c = 0; c < N; c++) begin
      if (m[pos] && pos != skip) return pos;
      pos = (pos == N - 1) ? 0 : pos + 1;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] vec_of(input int own);
    logic [N-1:0] v = '1;
    if (own >= 0) v[own] = 1'b0;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic [N-1:0] rq, input logic xe, input logic fm);
    int w;
    if (!(xe || m_own < 0)) return;
    if (!fm) begin
      w = seek(m_ptr, rq, -1);
      m_own = w;
      if (w >= 0) m_ptr = (w + 1) % N;
    end else begin
      w = seek(m_ptr, rq, P);
      if (m_turn == 1 && rq[P]) begin
        m_own = P; m_turn = 0;
      end else if (w >= 0) begin
        m_own = w; m_ptr = (w + 1) % N; m_turn = 1;
      end else if (rq[P]) begin
        m_own = P; m_turn = 0;
      end else begin
        m_own = -1;
      end
    end
  endtask

  // Apply inputs, let one edge pass, compare with the model.
  task automatic cyc(input logic [N-1:0] rq, input logic xe, input logic fm);
    req_n = ~rq; xfer_end = xe; fair_mode = fm;
    model_step(rq, xe, fm);
    @(posedge clk); #5;
    check($onehot0(~gnt_n), "R1", gnt_n, vec_of(m_own));
    check(gnt_n === vec_of(m_own), fm ? "R8" : "R6", gnt_n, vec_of(m_own));
  endtask

  task automatic expect_owner(input int own, input string tag);
    check(gnt_n === vec_of(own), tag, gnt_n, vec_of(own));
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int fm_r;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #5;
    expect_owner(-1, "R2 in reset");
    rst_n = 1'b1;
    @(posedge clk); #5;
    expect_owner(-1, "R2 after reset");

    // R5: lone requester far from the pointer (pointer at 0)
    cyc(4'b0100, 1'b0, 1'b0);
    expect_owner(2, "R5 lone requester");
    // R3: hold against other requests and a vanished request
    cyc(4'b1011, 1'b0, 1'b0);
    cyc(4'b0000, 1'b0, 1'b0);
    cyc(4'b1111, 1'b0, 1'b0);
    expect_owner(2, "R3 hold until strobe");
    // R10: release with nothing pending
    cyc(4'b0000, 1'b1, 1'b0);
    expect_owner(-1, "R10 release");
    cyc(4'b0000, 1'b0, 1'b0);
    expect_owner(-1, "R10 stays idle");
    // R6: plain rotation from pointer 3: 3,0,1,2,3
    cyc(4'b1111, 1'b0, 1'b0);
    expect_owner(3, "R6 order step0");
    for (int s = 0; s < 4; s++) begin
      cyc(4'b1111, 1'b1, 1'b0);
      expect_owner(s == 3 ? 3 : s, "R6 order");
    end
    cyc(4'b0000, 1'b1, 1'b0);
    expect_owner(-1, "R10 release before fair");
    // R7 R8: fair rotation, all requesting: 0,1,0,2,0,3,0,1
    begin
      int seq [8] = '{0, 1, 0, 2, 0, 3, 0, 1};
      cyc(4'b1111, 1'b0, 1'b1);
      expect_owner(seq[0], "R7 first privileged slot");
      for (int s = 1; s < 8; s++) begin
        cyc(4'b1111, 1'b1, 1'b1);
        expect_owner(seq[s], (s % 2 == 0) ? "R7 alternation" : "R8 group rotation");
      end
    end
    // R9: privileged absent in its slot -> group master 2 (pointer at 2)
    cyc(4'b1100, 1'b1, 1'b1);
    expect_owner(2, "R9 slot donated to group");
    cyc(4'b0001, 1'b1, 1'b1);
    expect_owner(0, "R9 privileged in its slot");
    cyc(4'b0001, 1'b1, 1'b1);
    expect_owner(0, "R9 group slot to privileged");
    // R12: plain mode leaves the flag clear; back in fair mode group wins first
    cyc(4'b0000, 1'b1, 1'b0);
    cyc(4'b1000, 1'b0, 1'b0);
    cyc(4'b1001, 1'b1, 1'b1);
    expect_owner(3, "R12 flag untouched by plain mode");

    // Random mix checked against the model
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] rq;
      if (c % 250 == 0) fm_r = $urandom_range(0, 1);
      for (int b = 0; b < N; b++) rq[b] = ($urandom_range(0, 99) < 45);
      cyc(rq, ($urandom_range(0, 99) < 40), fm_r[0]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule